// File: doc/BRIEF.md
# Conditional Skip and Branch Decision Unit

This block decides the outcome of a conditional control-transfer instruction on a 16-bit accumulator machine and produces the program counter of the next instruction. It takes the instruction word, a flag that says whether the instruction occupies one or two words, the already-resolved effective address, the current PC, the accumulator and the carry and overflow indicators. Six modifier bits in the instruction each select one testable condition. A one-word instruction skips the following word when any selected condition holds. A two-word instruction jumps to the effective address only when none of the selected conditions holds, so an empty selection makes it an unconditional jump.

A mode bit asks the unit to release the active interrupt level. The release pulse is raised only when the skip or jump actually happens. Selecting the overflow test raises a pulse that clears the overflow indicator, whether or not control transfers. The indirect-addressing bit is not used here, because address resolution happens upstream.

The decision and the next PC are combinational and valid while `eval_i` is high. A two-state machine registers a result-valid strobe. Its states are ST_IDLE (no result pending) and ST_REPORT (a result was evaluated in the previous cycle). The transition eval_seen moves the machine from either state to ST_REPORT when `eval_i` is high. The transition quiet_cycle moves it from either state to ST_IDLE when `eval_i` is low. Reset places the machine in ST_IDLE.

Top module: `cond_xfer_unit`

## Requirements
- R1: One-word form (`two_word_i`=0): if any selected condition is true, `next_pc_o` = `pc_i` + 2.
- R2: One-word form: if no selected condition is true, including the case where none is selected, `next_pc_o` = `pc_i` + 1.
- R3: Two-word form (`two_word_i`=1): if no selected condition is true, `next_pc_o` = `eff_addr_i`. Otherwise `next_pc_o` = `pc_i` + 2.
- R4: The condition selects are instruction bits 15 to 10. Bit 15 selects overflow indicator off. Bit 14 selects carry indicator off. Bit 13 selects accumulator negative, and bit 12 selects accumulator positive (greater than zero), both as signed two's complement. Bit 11 selects accumulator even (bit 0 clear). Bit 10 selects accumulator equal to zero.
- R5: A two-word instruction with bits 15 to 10 all zero always sets `next_pc_o` = `eff_addr_i`.
- R6: `lvl_release_o` is 1 exactly when `eval_i`=1, instruction bit 9 = 1 and the skip or jump is taken.
- R7: `ovf_clear_o` is 1 exactly when `eval_i`=1 and instruction bit 15 = 1, whether or not the transfer is taken.
- R8: Instruction bit 8 (indirect flag) and bits 7 to 0 have no effect on any output.
- R9: PC arithmetic wraps modulo 2^16.
- R10: `result_valid_o` is 0 during and after reset until evaluation. It is 1 in the cycle after each cycle with `eval_i`=1 and 0 after a cycle with `eval_i`=0.
- R11: With `eval_i`=0, `ovf_clear_o` and `lvl_release_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Instruction present for evaluation this cycle |
| instr_i | input | 16 | Instruction word (condition selects, release and indirect bits) |
| two_word_i | input | 1 | 1 = two-word jump form, 0 = one-word skip form |
| eff_addr_i | input | 16 | Resolved effective address |
| pc_i | input | 16 | Address of the current instruction |
| acc_i | input | 16 | Accumulator |
| carry_i | input | 1 | Carry indicator |
| ovf_i | input | 1 | Overflow indicator |
| next_pc_o | output | 16 | Address of the next instruction |
| ovf_clear_o | output | 1 | Clear the overflow indicator |
| lvl_release_o | output | 1 | Release the active interrupt level |
| result_valid_o | output | 1 | Result evaluated in the previous cycle |

## Verification
`next_pc_o`, `ovf_clear_o` and `lvl_release_o` are due in the same cycle as the stimulus, with no register in their path. `result_valid_o` is due one clock edge later. The bench drives inputs on the falling edge and checks the combinational results 1 ns later, before the next rising edge. It checks the strobe at the following falling edge, after the rising edge has registered it. A sweep covers every condition mask, both formats, all indicator states, the release bit and a set of accumulator values against a reference model in the bench. Directed cases cover the wrap-around and the indirect bit.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    localparam int WORD_W   = 16;
    localparam int N_COND   = 6;
    localparam int COND_TOP = 15;
    localparam int COND_LO  = COND_TOP - N_COND + 1;
    localparam int REL_BIT  = 9;
    localparam int IND_BIT  = 8;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rep_state_t;
endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [N_COND-1:0] sel_i,
    input  logic [W-1:0]      acc_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output logic              any_hit_o
);
    // Index i corresponds to instruction bit COND_LO + i.
    logic [N_COND-1:0] state_true;
    logic acc_zero, acc_neg;

    assign acc_zero = (acc_i == '0);
    assign acc_neg  = acc_i[W-1];

    always_comb begin
        state_true[0] = acc_zero;               // bit 10: zero
        state_true[1] = ~acc_i[0];              // bit 11: even
        state_true[2] = ~acc_neg & ~acc_zero;   // bit 12: positive
        state_true[3] = acc_neg;                // bit 13: negative
        state_true[4] = ~carry_i;               // bit 14: carry off
        state_true[5] = ~ovf_i;                 // bit 15: overflow off
    end

    assign any_hit_o = |(sel_i & state_true);

    always_comb begin
        a_r4_empty_no_hit: assert (!((sel_i == '0) && any_hit_o));
    end
endmodule

// File: rtl/cbu_pc_select.sv
module cbu_pc_select
    import cbu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         two_word_i,
    input  logic         any_hit_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] eff_addr_i,
    output logic [W-1:0] next_pc_o,
    output logic         taken_o
);
    localparam logic [W-1:0] STEP1 = W'(1);
    localparam logic [W-1:0] STEP2 = W'(2);

    logic [W-1:0] pc_p1, pc_p2;
    assign pc_p1 = pc_i + STEP1;
    assign pc_p2 = pc_i + STEP2;

    always_comb begin
        if (two_word_i) begin
            taken_o   = ~any_hit_i;
            next_pc_o = taken_o ? eff_addr_i : pc_p2;
        end else begin
            taken_o   = any_hit_i;
            next_pc_o = taken_o ? pc_p2 : pc_p1;
        end
    end
endmodule

// File: rtl/cond_xfer_unit.sv
module cond_xfer_unit
    import cbu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_i,
    input  logic [15:0]  instr_i,
    input  logic         two_word_i,
    input  logic [W-1:0] eff_addr_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] acc_i,
    input  logic         carry_i,
    input  logic         ovf_i,
    output logic [W-1:0] next_pc_o,
    output logic         ovf_clear_o,
    output logic         lvl_release_o,
    output logic         result_valid_o
);
    logic [N_COND-1:0] cond_sel;
    logic any_hit, taken;
    rep_state_t state_q, state_d;

    assign cond_sel = instr_i[COND_TOP:COND_LO];

    cbu_cond_eval #(.W(W)) u_cond (
        .sel_i     (cond_sel),
        .acc_i     (acc_i),
        .carry_i   (carry_i),
        .ovf_i     (ovf_i),
        .any_hit_o (any_hit)
    );

    cbu_pc_select #(.W(W)) u_pcsel (
        .two_word_i (two_word_i),
        .any_hit_i  (any_hit),
        .pc_i       (pc_i),
        .eff_addr_i (eff_addr_i),
        .next_pc_o  (next_pc_o),
        .taken_o    (taken)
    );

    assign ovf_clear_o   = eval_i & instr_i[COND_TOP];
    assign lvl_release_o = eval_i & instr_i[REL_BIT] & taken;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = eval_i ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = eval_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_REPORT: result_valid_o = 1'b1;
            default:   result_valid_o = 1'b0;
        endcase
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> result_valid_o);
    a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !result_valid_o);
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |-> (!ovf_clear_o && !lvl_release_o));
    a_r6_release_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_release_o |-> instr_i[REL_BIT]);
    a_r5_unconditional: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && two_word_i && cond_sel == '0) |-> (next_pc_o == eff_addr_i));
    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && instr_i[COND_TOP]) |-> ovf_clear_o);
endmodule

// File: tb/cond_xfer_unit_tb.sv
module cond_xfer_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        two_word_i = 1'b0;
    logic [15:0] eff_addr_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] acc_i = '0;
    logic        carry_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic [15:0] next_pc_o;
    logic        ovf_clear_o, lvl_release_o, result_valid_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .instr_i(instr_i),
        .two_word_i(two_word_i), .eff_addr_i(eff_addr_i), .pc_i(pc_i),
        .acc_i(acc_i), .carry_i(carry_i), .ovf_i(ovf_i),
        .next_pc_o(next_pc_o), .ovf_clear_o(ovf_clear_o),
        .lvl_release_o(lvl_release_o), .result_valid_o(result_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model built from the condition definitions in R4.
    function automatic bit ref_hit(input logic [15:0] ins, input logic [15:0] a,
                                   input logic c, input logic o);
        bit h = 1'b0;
        if (ins[15] && !o) h = 1'b1;
        if (ins[14] && !c) h = 1'b1;
        if (ins[13] && $signed(a) < 0) h = 1'b1;
        if (ins[12] && $signed(a) > 0) h = 1'b1;
        if (ins[11] && a[0] == 1'b0) h = 1'b1;
        if (ins[10] && a == 16'h0) h = 1'b1;
        return h;
    endfunction

    // Drive one evaluation, check combinational results, then the strobe.
    task automatic run_one(input logic [15:0] ins, input logic tw, input logic [15:0] ea,
                           input logic [15:0] pc, input logic [15:0] a,
                           input logic c, input logic o, input string req);
        bit hit, tk;
        logic [15:0] exp_pc;
        hit = ref_hit(ins, a, c, o);
        tk  = tw ? !hit : hit;
        if (tw) exp_pc = tk ? ea : pc + 16'd2;
        else    exp_pc = tk ? pc + 16'd2 : pc + 16'd1;
        @(negedge clk);
        eval_i = 1'b1; instr_i = ins; two_word_i = tw; eff_addr_i = ea;
        pc_i = pc; acc_i = a; carry_i = c; ovf_i = o;
        #1;
        chk(next_pc_o == exp_pc, req, next_pc_o, exp_pc);
        chk(ovf_clear_o == ins[15], "R7", ovf_clear_o, ins[15]);
        chk(lvl_release_o == (ins[9] & tk), "R6", lvl_release_o, ins[9] & tk);
        @(negedge clk);
        eval_i = 1'b0;
        chk(result_valid_o == 1'b1, "R10", result_valid_o, 1);
        #1;
        chk(ovf_clear_o == 1'b0 && lvl_release_o == 1'b0, "R11",
            {ovf_clear_o, lvl_release_o}, 0);
    endtask

    task automatic t_reset;
        #1;
        chk(result_valid_o == 1'b0, "R10 reset", result_valid_o, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result_valid_o == 1'b0, "R10 idle", result_valid_o, 0);
    endtask

    task automatic t_sweep;
        logic [15:0] accs [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h7FFF, 16'h8000};
        for (int m = 0; m < 64; m++)
            for (int tw = 0; tw < 2; tw++)
                for (int c = 0; c < 2; c++)
                    for (int o = 0; o < 2; o++)
                        for (int ai = 0; ai < 6; ai++)
                            for (int r = 0; r < 2; r++) begin
                                logic [15:0] ins;
                                ins = {m[5:0], r[0], ai[0], 8'h5A};
                                run_one(ins, tw[0], 16'h3C00 + 16'(m), 16'h1200 + 16'(ai), accs[ai],
                                        c[0], o[0], tw[0] ? "R3 sweep" : "R1/R2 sweep");
                            end
    endtask

    task automatic t_directed;
        // R1: carry off selected, carry clear -> skip
        run_one(16'h4000, 1'b0, 16'h0, 16'h0100, 16'h0, 1'b0, 1'b1, "R1");
        // R2: empty mask one-word -> +1
        run_one(16'h0000, 1'b0, 16'h0, 16'h0100, 16'h0, 1'b0, 1'b0, "R2");
        // R5: empty mask two-word -> jump
        run_one(16'h0200, 1'b1, 16'hBEEF, 16'h0100, 16'h5, 1'b1, 1'b1, "R5");
        // R3/R4: zero and carry-off selected, acc nonzero, carry set -> jump
        run_one(16'h4400, 1'b1, 16'h0777, 16'h0300, 16'h0003, 1'b1, 1'b1, "R3 R4");
        run_one(16'h4400, 1'b1, 16'h0777, 16'h0300, 16'h0000, 1'b1, 1'b1, "R3 R4");
        // R9: wraps
        run_one(16'h0400, 1'b0, 16'h0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, "R9");
        run_one(16'h0000, 1'b0, 16'h0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, "R9");
        run_one(16'h0400, 1'b1, 16'h0, 16'hFFFE, 16'h0000, 1'b0, 1'b0, "R9");
        // R6: release with bit 9 when not taken stays low
        run_one(16'h0600, 1'b0, 16'h0, 16'h0010, 16'h0001, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_indirect;
        // R8: same instruction with bit 8 and low bits changed gives same outputs
        logic [15:0] pa; logic oa, ra;
        @(negedge clk);
        eval_i = 1'b1; instr_i = 16'h8200; two_word_i = 1'b1; eff_addr_i = 16'h2468;
        pc_i = 16'h0040; acc_i = 16'h0; carry_i = 1'b1; ovf_i = 1'b1;
        #1; pa = next_pc_o; oa = ovf_clear_o; ra = lvl_release_o;
        instr_i = 16'h83FF;
        #1;
        chk(next_pc_o == pa && ovf_clear_o == oa && lvl_release_o == ra, "R8",
            {next_pc_o, ovf_clear_o, lvl_release_o}, {pa, oa, ra});
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_directed();
        t_indirect();
        t_sweep();
        // R10: strobe drops after a quiet cycle
        @(negedge clk);
        chk(result_valid_o == 1'b0, "R10 drop", result_valid_o, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule